// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block produces the external bus cycles for a small 8-bit controller core. The core's code-fetch requests and data read or write requests reach the pins through a single shared byte-wide port. That port carries the low address byte at the start of each access and the data byte later in the same access. A latch strobe lets board logic capture the low address byte. A separate byte port carries the high address. There are three active-low strobes: one for code fetches, one for data reads and one for data writes.

Each external access occupies one fixed slot of `SLOT_LEN` clocks, six by default. Two slots therefore fit in a 12-clock machine cycle, and back-to-back requests fill the bus without gaps. A fetch goes out on the bus only while the external-code input is low. Otherwise it completes at once and is flagged as served internally. A data access with a narrow 8-bit address leaves the high address port unchanged, so board logic can treat those bits as a page select.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is high and directly after it, all three strobes are high, the latch strobe and `mux_oe` are low, `done` is low, `req_ready` is high, and `addr_hi` holds all ones.
- R2: An external access accepted at clock edge E raises `addr_stb` after edges E and E+1 (2 clocks). `mux_out` carries `req_addr[7:0]` with `mux_oe` high from edge E through edge E+2.
- R3: Its data strobe is low after edges E+3, E+4 and E+5. A read or fetch keeps `mux_oe` low while its strobe is low. A write drives `req_wdata` with `mux_oe` high while `data_wr_n` is low.
- R4: `req_kind` encodes 00 as a code fetch (uses `code_rd_n`), 01 as a data read (uses `data_rd_n`), 10 as a data write (uses `data_wr_n`), and 11 as a data read. No two strobes are ever low together, and no strobe is low while `addr_stb` is high.
- R5: A fetch accepted while `ext_code_n` is high makes no bus activity. `done` and `done_int` are high in the single cycle after the accepting edge. A fetch with `ext_code_n` low goes to the bus.
- R6: A fetch, or a data access with `req_wide`=1, puts `req_addr[15:8]` on `addr_hi` from edge E and holds it afterwards. A data access with `req_wide`=0 leaves `addr_hi` unchanged.
- R7: An external access raises `done` for exactly one cycle, after edge E+6. For a read or fetch, `rdata` then holds the byte seen on `mux_in` just before that edge. For a write, `rdata` is unchanged. `done_int` stays low.
- R8: `req_ready` is low for the first five clocks of a slot. A held external request is accepted at edge E+6, so external accesses start every 6 clocks. A held internal fetch waits until the bus is idle and is accepted at edge E+7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock (oscillator rate) |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core has a request |
| req_ready | output | 1 | Request is taken on this edge if valid |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| req_wide | input | 1 | Data access uses the full 16-bit address |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write byte |
| ext_code_n | input | 1 | Low: fetches go to the external bus |
| done | output | 1 | One-cycle completion pulse |
| done_int | output | 1 | Completion was an internally served fetch |
| rdata | output | 8 | Captured read or fetch byte |
| mux_out | output | 8 | Shared port, outgoing value |
| mux_oe | output | 1 | Shared port output enable |
| mux_in | input | 8 | Shared port, incoming value |
| addr_hi | output | 8 | High address byte port |
| addr_stb | output | 1 | Address latch strobe, active high |
| code_rd_n | output | 1 | Code fetch strobe, active low |
| data_rd_n | output | 1 | Data read strobe, active low |
| data_wr_n | output | 1 | Data write strobe, active low |

## Verification
All results are counted from the edge that accepts a request. The latch strobe and address byte appear after that edge and the next one. The data strobe covers the three clocks after edges +3 to +5. `done` with captured data follows edge +6, and an internal fetch's `done` follows the accepting edge itself. The bench changes inputs and reads outputs on falling edges and stamps every observation with a rising-edge counter. Each check then compares a recorded stamp against the acceptance stamp plus these fixed offsets. Back-to-back and held-off requests are checked the same way, against offsets of 6 and 7 between acceptances.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  // request kind codes presented by the core
  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_READ  = 2'b01;
  localparam logic [1:0] KIND_WRITE = 2'b10;
  localparam logic [1:0] KIND_READX = 2'b11;  // decoded as a data read
endpackage

// File: rtl/xbus_seq.sv
// Slot sequencer: handshake, phase counter and the request held for the slot.
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int SLOT_LEN = 6,
  parameter int PH_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ext_code_n,
  output logic              req_ready,
  output logic              busy_d,
  output logic [PH_W-1:0]   ph_d,
  output logic [1:0]        sel_kind,
  output logic              sel_wide,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [DATA_W-1:0] sel_wdata,
  output logic              fin,
  output logic              fin_wr,
  output logic              int_hit
);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOT_LEN - 1);

  logic              busy_q;
  logic [PH_W-1:0]   ph_q;
  logic [1:0]        cur_kind;
  logic              cur_wide;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic              last, in_ext, accept;

  always_comb begin
    last      = busy_q && (ph_q == PH_LAST);
    in_ext    = (req_kind != KIND_FETCH) || !ext_code_n;
    // a slot may be chained onto the last phase only by another external access
    req_ready = !busy_q || (last && in_ext);
    accept    = req_valid && req_ready;
    int_hit   = accept && !in_ext;
    fin       = last;
    fin_wr    = (cur_kind == KIND_WRITE);

    busy_d    = busy_q;
    ph_d      = ph_q;
    sel_kind  = cur_kind;
    sel_wide  = cur_wide;
    sel_addr  = cur_addr;
    sel_wdata = cur_wdata;
    if (accept && in_ext) begin
      busy_d    = 1'b1;
      ph_d      = '0;
      sel_kind  = req_kind;
      sel_wide  = req_wide || (req_kind == KIND_FETCH);
      sel_addr  = req_addr;
      sel_wdata = req_wdata;
    end else if (last) begin
      busy_d = 1'b0;
      ph_d   = '0;
    end else if (busy_q) begin
      ph_d = ph_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      ph_q      <= '0;
      cur_kind  <= KIND_FETCH;
      cur_wide  <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else begin
      busy_q    <= busy_d;
      ph_q      <= ph_d;
      cur_kind  <= sel_kind;
      cur_wide  <= sel_wide;
      cur_addr  <= sel_addr;
      cur_wdata <= sel_wdata;
    end
  end
endmodule

// File: rtl/xbus_pins.sv
// Pin register stage: every bus pin is a flop loaded from the next slot state.
module xbus_pins
  import xbus_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PH_W      = 3,
  parameter int LATCH_LEN = 2,
  parameter int STB_START = 3,
  parameter int HI_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_d,
  input  logic [PH_W-1:0]   ph_d,
  input  logic [1:0]        sel_kind,
  input  logic              sel_wide,
  input  logic [ADDR_W-1:0] sel_addr,
  input  logic [DATA_W-1:0] sel_wdata,
  output logic              addr_stb,
  output logic              code_rd_n,
  output logic              data_rd_n,
  output logic              data_wr_n,
  output logic              mux_oe,
  output logic [DATA_W-1:0] mux_out,
  output logic [HI_W-1:0]   addr_hi
);
  logic in_latch, in_addr, in_stb, is_fetch, is_wr, first_ph;

  always_comb begin
    in_latch = busy_d && (ph_d < PH_W'(LATCH_LEN));
    in_addr  = busy_d && (ph_d < PH_W'(STB_START));
    in_stb   = busy_d && (ph_d >= PH_W'(STB_START));
    first_ph = busy_d && (ph_d == '0);
    is_fetch = (sel_kind == KIND_FETCH);
    is_wr    = (sel_kind == KIND_WRITE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_stb  <= 1'b0;
      code_rd_n <= 1'b1;
      data_rd_n <= 1'b1;
      data_wr_n <= 1'b1;
      mux_oe    <= 1'b0;
      mux_out   <= '0;
      addr_hi   <= '1;
    end else begin
      addr_stb  <= in_latch;
      code_rd_n <= !(in_stb && is_fetch);
      data_rd_n <= !(in_stb && !is_fetch && !is_wr);
      data_wr_n <= !(in_stb && is_wr);
      mux_oe    <= in_addr || (in_stb && is_wr);
      if (in_addr)
        mux_out <= sel_addr[DATA_W-1:0];
      else if (in_stb && is_wr)
        mux_out <= sel_wdata;
      if (first_ph && sel_wide)
        addr_hi <= sel_addr[ADDR_W-1:DATA_W];
    end
  end
endmodule

// File: rtl/xbus_capture.sv
// Completion stage: done pulses and the captured byte.
module xbus_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fin,
  input  logic              fin_wr,
  input  logic              int_hit,
  input  logic [DATA_W-1:0] mux_in,
  output logic              done,
  output logic              done_int,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      done_int <= 1'b0;
      rdata    <= '0;
    end else begin
      done     <= fin || int_hit;
      done_int <= int_hit;
      if (fin && !fin_wr)
        rdata <= mux_in;
    end
  end
endmodule

// File: rtl/xbus_ctrl.sv
// Top: multiplexed external bus controller.
module xbus_ctrl #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int SLOT_LEN  = 6,
  parameter int LATCH_LEN = 2,
  parameter int STB_START = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ext_code_n,
  output logic              done,
  output logic              done_int,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] mux_out,
  output logic              mux_oe,
  input  logic [DATA_W-1:0] mux_in,
  output logic [ADDR_W-DATA_W-1:0] addr_hi,
  output logic              addr_stb,
  output logic              code_rd_n,
  output logic              data_rd_n,
  output logic              data_wr_n
);
  localparam int PH_W = (SLOT_LEN > 2) ? $clog2(SLOT_LEN) : 1;
  localparam int HI_W = ADDR_W - DATA_W;

  logic              busy_d;
  logic [PH_W-1:0]   ph_d;
  logic [1:0]        sel_kind;
  logic              sel_wide;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;
  logic              fin, fin_wr, int_hit;

  xbus_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_LEN(SLOT_LEN), .PH_W(PH_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_kind(req_kind), .req_wide(req_wide),
    .req_addr(req_addr), .req_wdata(req_wdata), .ext_code_n(ext_code_n),
    .req_ready(req_ready),
    .busy_d(busy_d), .ph_d(ph_d),
    .sel_kind(sel_kind), .sel_wide(sel_wide), .sel_addr(sel_addr), .sel_wdata(sel_wdata),
    .fin(fin), .fin_wr(fin_wr), .int_hit(int_hit)
  );

  xbus_pins #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PH_W(PH_W),
    .LATCH_LEN(LATCH_LEN), .STB_START(STB_START), .HI_W(HI_W)
  ) u_pins (
    .clk(clk), .rst(rst),
    .busy_d(busy_d), .ph_d(ph_d),
    .sel_kind(sel_kind), .sel_wide(sel_wide), .sel_addr(sel_addr), .sel_wdata(sel_wdata),
    .addr_stb(addr_stb), .code_rd_n(code_rd_n), .data_rd_n(data_rd_n),
    .data_wr_n(data_wr_n), .mux_oe(mux_oe), .mux_out(mux_out), .addr_hi(addr_hi)
  );

  xbus_capture #(
    .DATA_W(DATA_W)
  ) u_cap (
    .clk(clk), .rst(rst),
    .fin(fin), .fin_wr(fin_wr), .int_hit(int_hit), .mux_in(mux_in),
    .done(done), .done_int(done_int), .rdata(rdata)
  );
endmodule

// File: rtl/xbus_ctrl_chk.sv
// Protocol checker attached to the top module.
module xbus_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic              req_wide,
  input logic              ext_code_n,
  input logic              done,
  input logic              done_int,
  input logic              mux_oe,
  input logic [ADDR_W-DATA_W-1:0] addr_hi,
  input logic              addr_stb,
  input logic              code_rd_n,
  input logic              data_rd_n,
  input logic              data_wr_n
);
  logic take;
  assign take = req_valid && req_ready;

  // R1: reset leaves the bus idle
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (code_rd_n && data_rd_n && data_wr_n && !addr_stb && !mux_oe && !done));

  // R2: the port drives while the latch strobe is high
  a_r2_latch_drives: assert property (@(posedge clk) disable iff (rst)
    addr_stb |-> mux_oe);

  // R3: the port is released during read and fetch strobes
  a_r3_release_on_read: assert property (@(posedge clk) disable iff (rst)
    (!code_rd_n || !data_rd_n) |-> !mux_oe);

  // R3: the port drives during the write strobe
  a_r3_drive_on_write: assert property (@(posedge clk) disable iff (rst)
    !data_wr_n |-> mux_oe);

  // R4: at most one strobe low at a time
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $countones({~code_rd_n, ~data_rd_n, ~data_wr_n}) <= 1);

  // R4: no strobe overlaps the latch strobe
  a_r4_strobe_apart: assert property (@(posedge clk) disable iff (rst)
    addr_stb |-> (code_rd_n && data_rd_n && data_wr_n));

  // R5: an internally served fetch completes at once with a quiet bus
  a_r5_internal_quiet: assert property (@(posedge clk) disable iff (rst)
    (take && req_kind == 2'b00 && ext_code_n) |=> (done && done_int && !addr_stb && code_rd_n));

  // R6: a narrow data access keeps the high address byte
  a_r6_narrow_keeps_hi: assert property (@(posedge clk) disable iff (rst)
    (take && req_kind != 2'b00 && !req_wide) |=> $stable(addr_hi));

  // R8: no new request is taken while the latch strobe is high
  a_r8_busy_in_latch: assert property (@(posedge clk) disable iff (rst)
    addr_stb |-> !req_ready);
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .req_wide(req_wide), .ext_code_n(ext_code_n),
  .done(done), .done_int(done_int), .mux_oe(mux_oe), .addr_hi(addr_hi),
  .addr_stb(addr_stb), .code_rd_n(code_rd_n), .data_rd_n(data_rd_n),
  .data_wr_n(data_wr_n)
);

// File: tb/tb_xbus_ctrl.sv
`timescale 1ns/1ps
module tb_xbus_ctrl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, req_valid, req_ready, req_wide, ext_code_n;
  logic [1:0]  req_kind;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, rdata, mux_out, mux_in, addr_hi;
  logic        done, done_int, mux_oe, addr_stb, code_rd_n, data_rd_n, data_wr_n;

  xbus_ctrl dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .ext_code_n(ext_code_n), .done(done),
    .done_int(done_int), .rdata(rdata), .mux_out(mux_out), .mux_oe(mux_oe),
    .mux_in(mux_in), .addr_hi(addr_hi), .addr_stb(addr_stb),
    .code_rd_n(code_rd_n), .data_rd_n(data_rd_n), .data_wr_n(data_wr_n)
  );

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // ---------------- external latch and memory models ----------------
  function automatic logic [7:0] code_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction
  function automatic logic [7:0] dinit(input logic [9:0] i);
    return i[7:0] ^ {i[9:8], 6'h15};
  endfunction

  logic [7:0] lat_lo = 8'h00;
  logic [7:0] dmem [0:1023];
  bit         dval [0:1023];
  logic [9:0] didx;
  assign didx   = {addr_hi[1:0], lat_lo};
  assign mux_in = !code_rd_n ? code_byte({addr_hi, lat_lo}) :
                  !data_rd_n ? (dval[didx] ? dmem[didx] : dinit(didx)) : 8'hA5;

  // ---------------- bus monitor ----------------
  bit mon_clr = 1'b0;
  int m_stb_n, m_stb_first, m_st_cnt, m_st_first, m_code, m_rd, m_wr, m_oe_bad, m_done_cyc;
  logic [7:0] m_lo_seen, m_rdata;
  bit m_done_int;

  always @(negedge clk) begin
    if (addr_stb) lat_lo = mux_out;
    if (!data_wr_n) begin dmem[didx] = mux_out; dval[didx] = 1'b1; end
    if (mon_clr) begin
      m_stb_n = 0; m_stb_first = -1; m_st_cnt = 0; m_st_first = -1;
      m_code = 0; m_rd = 0; m_wr = 0; m_oe_bad = 0; m_done_cyc = -1;
      m_lo_seen = 8'h00; m_rdata = 8'h00; m_done_int = 1'b0;
    end else begin
      if (addr_stb) begin
        if (m_stb_n == 0) m_stb_first = cyc;
        m_stb_n++;
        m_lo_seen = mux_out;
        if (!mux_oe) m_oe_bad++;
      end
      if (!code_rd_n || !data_rd_n || !data_wr_n) begin
        if (m_st_cnt == 0) m_st_first = cyc;
        m_st_cnt++;
      end
      if (!code_rd_n) m_code++;
      if (!data_rd_n) m_rd++;
      if (!data_wr_n) m_wr++;
      if ((!code_rd_n || !data_rd_n) && mux_oe) m_oe_bad++;
      if (!data_wr_n && !mux_oe) m_oe_bad++;
      if (done && m_done_cyc < 0) begin
        m_done_cyc = cyc; m_done_int = done_int; m_rdata = rdata;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic mon_clear();
    mon_clr = 1'b1;
    @(negedge clk); #1;
    mon_clr = 1'b0;
  endtask

  task automatic issue(input logic [1:0] k, input bit w, input logic [15:0] a,
                       input logic [7:0] d, output int acc);
    req_kind = k; req_wide = w; req_addr = a; req_wdata = d; req_valid = 1'b1;
    acc = -1;
    for (int i = 0; i < 40 && acc < 0; i++) begin
      bit r;
      r = req_ready;
      @(posedge clk); @(negedge clk); #1;
      if (r) acc = cyc;
    end
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 40 && m_done_cyc < 0; i++) begin
      @(negedge clk); #1;
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    // R1
    chk(code_rd_n && data_rd_n && data_wr_n, "R1 strobes high", {code_rd_n, data_rd_n, data_wr_n}, 7);
    chk(!addr_stb && !mux_oe && !done, "R1 latch/oe/done low", {addr_stb, mux_oe, done}, 0);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(addr_hi == 8'hFF, "R1 high byte", addr_hi, 8'hFF);
  endtask

  task automatic t_access(input logic [1:0] k, input bit w, input logic [15:0] a,
                          input logic [7:0] d, input logic [7:0] exp_rd);
    int acc;
    logic [7:0] hi0, rd0;
    bit fe, wr;
    hi0 = addr_hi; rd0 = rdata; fe = (k == 2'b00); wr = (k == 2'b10);
    mon_clear();
    issue(k, w, a, d, acc);
    wait_done();
    chk(m_stb_first == acc, "R2 latch start", m_stb_first, acc);
    chk(m_stb_n == 2, "R2 latch width", m_stb_n, 2);
    chk(m_lo_seen == a[7:0], "R2 low byte", m_lo_seen, a[7:0]);
    chk(m_st_first == acc + 3, "R3 strobe start", m_st_first, acc + 3);
    chk(m_st_cnt == 3, "R3 strobe width", m_st_cnt, 3);
    chk(m_oe_bad == 0, "R3 port direction", m_oe_bad, 0);
    chk(m_code == (fe ? 3 : 0) && m_rd == ((!fe && !wr) ? 3 : 0) && m_wr == (wr ? 3 : 0),
        "R4 strobe select", {m_code[3:0], m_rd[3:0], m_wr[3:0]},
        {fe ? 4'd3 : 4'd0, (!fe && !wr) ? 4'd3 : 4'd0, wr ? 4'd3 : 4'd0});
    chk(m_done_cyc == acc + 6, "R7 done timing", m_done_cyc, acc + 6);
    chk(m_rdata == (wr ? rd0 : exp_rd), "R7 captured byte", m_rdata, wr ? rd0 : exp_rd);
    chk(!m_done_int, "R7 not internal", m_done_int, 0);
    chk(addr_hi == ((w || fe) ? a[15:8] : hi0), "R6 high byte", addr_hi, (w || fe) ? a[15:8] : hi0);
    @(negedge clk); #1;
    chk(!done, "R7 single pulse", done, 0);
  endtask

  task automatic t_internal();
    int acc;
    logic [7:0] hi0, rd0;
    hi0 = addr_hi; rd0 = rdata;
    ext_code_n = 1'b1;
    mon_clear();
    issue(2'b00, 1'b1, 16'h0400, 8'h00, acc);
    wait_done();
    chk(m_done_cyc == acc && m_done_int, "R5 internal done", m_done_cyc, acc);
    chk(m_stb_n == 0 && m_st_cnt == 0, "R5 quiet bus", m_stb_n + m_st_cnt, 0);
    chk(rdata == rd0 && addr_hi == hi0, "R5 state kept", {rdata, addr_hi}, {rd0, hi0});
    ext_code_n = 1'b0;
  endtask

  task automatic t_back_to_back();
    int a1, a2, lowcnt;
    a1 = -1; a2 = -1; lowcnt = 0;
    mon_clear();
    req_kind = 2'b00; req_wide = 1'b1; req_addr = 16'h2345; req_wdata = 8'h00; req_valid = 1'b1;
    for (int i = 0; i < 40 && a2 < 0; i++) begin
      bit r;
      r = req_ready;
      if (a1 >= 0 && !r) lowcnt++;
      @(posedge clk); @(negedge clk); #1;
      if (r) begin
        if (a1 < 0) begin a1 = cyc; req_addr = 16'h2346; end
        else begin a2 = cyc; req_valid = 1'b0; end
      end
    end
    chk(a2 == a1 + 6, "R8 slot spacing", a2 - a1, 6);
    chk(lowcnt == 5, "R8 ready low", lowcnt, 5);
    wait_done();
    chk(m_rdata == code_byte(16'h2345), "R7 first fetch", m_rdata, code_byte(16'h2345));
    while (cyc < a2 + 6) begin @(negedge clk); #1; end
    chk(done && rdata == code_byte(16'h2346), "R7 second fetch", rdata, code_byte(16'h2346));
    chk(m_stb_n == 4, "R2 two latch pulses each", m_stb_n, 4);
  endtask

  task automatic t_holdoff();
    int a1, a2;
    mon_clear();
    issue(2'b01, 1'b1, 16'h0310, 8'h00, a1);
    ext_code_n = 1'b1;
    issue(2'b00, 1'b1, 16'h0500, 8'h00, a2);
    chk(a2 == a1 + 7, "R8 internal waits", a2 - a1, 7);
    chk(done && done_int, "R5 held internal done", {done, done_int}, 3);
    chk(m_done_cyc == a1 + 6 && m_rdata == dinit(10'h310), "R7 read before hold", m_rdata, dinit(10'h310));
    ext_code_n = 1'b0;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    rst = 1'b1; req_valid = 1'b0; req_kind = 2'b00; req_wide = 1'b0;
    req_addr = 16'h0000; req_wdata = 8'h00; ext_code_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    rst = 1'b0;
    @(negedge clk); #1;
    t_reset();
    t_access(2'b00, 1'b0, 16'h1234, 8'h00, code_byte(16'h1234));   // R5 external fetch, R6 fetch is wide
    t_access(2'b10, 1'b1, 16'h0250, 8'h9C, 8'h00);                 // wide write sets page 2
    t_access(2'b01, 1'b0, 16'hEE50, 8'h00, 8'h9C);                 // narrow read, page kept
    t_access(2'b10, 1'b0, 16'h007B, 8'h11, 8'h00);                 // narrow write
    t_access(2'b01, 1'b1, 16'h027B, 8'h00, 8'h11);                 // wide read back
    t_access(2'b11, 1'b0, 16'h0010, 8'h00, dinit(10'h210));        // R4 code 11 reads
    t_access(2'b01, 1'b1, 16'h0310, 8'h00, dinit(10'h310));
    t_internal();
    t_back_to_back();
    t_holdoff();
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule